// File: doc/BRIEF.md
# Configuration Command Sequencer

This block sits between a host that configures a data-converter front end and an SPI master that reaches the devices on the board. The host puts an 8-bit opcode and two argument words on its inputs and raises a commit strobe. The sequencer starts on the rising edge of that strobe and checks the command. It then sends one or two register read or write requests on a request/acknowledge port. The SPI master serves those requests. Its serial shifting and the devices' register maps are outside this block.

The sequencer reports four things: an idle flag, a completion status for the last command, a return byte for reads, and a sticky error flag. The error flag means a reinitialize is needed. The block also keeps the current sample-clock source and the clock-export setting, so it can turn away commands that conflict with them.

Top module: `cfg_cmd_seq`

## Requirements
- R1: A command starts only on a low-to-high transition of `commit_i` seen while `idle_o` is high. Holding `commit_i` high starts nothing more. An edge that arrives while the block is busy is dropped.
- R2: `idle_o` falls in the cycle after an accepted edge. It rises in the cycle after the final request is acknowledged. A command that completes without a request keeps `idle_o` low for exactly one cycle.
- R3: Opcode 0x00 selects the clock source, with code `arg0_i` in 0..3. It writes device 1, register 0x0010, with the code. After the acknowledge, `clk_src_o` takes the code, and code 2 (external sample clock) clears `clk_exp_o`. A code above 3 completes with status 2 and issues no request.
- R4: Opcode 0x08 sets clock export: enable when `arg0_i` is nonzero. It writes device 1, register 0x0011, with 1 or 0, and `clk_exp_o` follows after the acknowledge. An enable while `clk_src_o` is 2 completes with status 3, issues no request and changes no state.
- R5: Opcode 0x02 (gain) writes device 0, register 0x0004+ch, and opcode 0x03 (offset) writes device 0, register 0x0008+ch. In both cases the data is `arg0_i[8:0]` and ch is `arg1_i`. A ch above 1 gives status 2 and no request.
- R6: Opcode 0x04 (interleave) issues two writes to device 0 in order: register 0x000C with `arg0_i[0]`, then register 0x000D with ch. A ch above 1 gives status 2 and no request.
- R7: Opcode 0x01 (self-calibration) writes device 0, register 0x0001, with 1. Opcode 0x05 (frequency DAC) writes device 3, register 0x0000, with `arg0_i`.
- R8: Opcode 0x06 reads device 5 at address `arg0_i` with write data 0, and `ret_o` takes `req_rdata_i` at the acknowledge. Opcode 0x07 writes device 5 at address `arg0_i` with `arg1_i`. No other command changes `ret_o`.
- R9: A command that succeeds leaves status 0. An undefined opcode completes with status 1 and issues no request.
- R10: If a request stays unacknowledged for TIMEOUT (1024) cycles, the command aborts with status 4 and `err_o` becomes 1. `err_o` then stays 1 through any other command.
- R11: Opcode 0xFF writes device 1, register 0x0010, with 0. On its acknowledge it clears `err_o`, sets `clk_src_o` to 0, clears `clk_exp_o` and leaves status 0.
- R12: After reset, `idle_o` is 1, while `status_o`, `ret_o`, `err_o`, `req_valid_o`, `clk_src_o` and `clk_exp_o` are all 0.
- R13: While `req_valid_o` is high and no acknowledge has arrived, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_op_i | input | 8 | Command opcode |
| cmd_arg0_i | input | 16 | First argument word |
| cmd_arg1_i | input | 8 | Second argument word |
| commit_i | input | 1 | Start strobe, rising edge |
| idle_o | output | 1 | Ready for a command |
| status_o | output | 8 | Completion code of last command |
| ret_o | output | 8 | Read return value |
| err_o | output | 8 | Sticky error, nonzero means reinitialize |
| clk_src_o | output | 2 | Current clock source code |
| clk_exp_o | output | 1 | Clock export enabled |
| req_valid_o | output | 1 | Downstream request pending |
| req_write_o | output | 1 | 1 write, 0 read |
| req_dev_o | output | 3 | Target device |
| req_addr_o | output | 16 | Register address |
| req_wdata_o | output | 16 | Write data |
| req_ack_i | input | 1 | Request served |
| req_rdata_i | input | 8 | Read data, valid with ack |

## Verification
Suppose the commit edge is sampled at edge E. Then `idle_o` is low one cycle later. A command rejected at decode completes at E+2, with status and idle both valid. A command that issues requests asserts `req_valid_o` from E+2 and completes one cycle after its last acknowledge. The bench drives every input on the falling edge and samples on the falling edge. It checks idle exactly one half-cycle after the commit edge. For all other results it waits for `idle_o` and only then reads status, return, clock state and the logged requests. Request fields are logged on the falling edge just before the acknowledge edge, so each logged value is the one the acknowledge closes.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam logic [7:0] OP_CLK_SRC  = 8'h00;
  localparam logic [7:0] OP_SELF_CAL = 8'h01;
  localparam logic [7:0] OP_GAIN     = 8'h02;
  localparam logic [7:0] OP_OFFSET   = 8'h03;
  localparam logic [7:0] OP_ILV      = 8'h04;
  localparam logic [7:0] OP_FDAC     = 8'h05;
  localparam logic [7:0] OP_EE_RD    = 8'h06;
  localparam logic [7:0] OP_EE_WR    = 8'h07;
  localparam logic [7:0] OP_CLK_EXP  = 8'h08;
  localparam logic [7:0] OP_REINIT   = 8'hFF;

  localparam logic [7:0] ST_OK       = 8'd0;
  localparam logic [7:0] ST_BAD_OP   = 8'd1;
  localparam logic [7:0] ST_BAD_ARG  = 8'd2;
  localparam logic [7:0] ST_CONFLICT = 8'd3;
  localparam logic [7:0] ST_TIMEOUT  = 8'd4;

  localparam logic [2:0] DEV_ADC   = 3'd0;
  localparam logic [2:0] DEV_CLK   = 3'd1;
  localparam logic [2:0] DEV_FDAC  = 3'd3;
  localparam logic [2:0] DEV_EE    = 3'd5;

  localparam logic [15:0] RG_CAL     = 16'h0001;
  localparam logic [15:0] RG_GAIN    = 16'h0004;
  localparam logic [15:0] RG_OFFS    = 16'h0008;
  localparam logic [15:0] RG_ILV_EN  = 16'h000C;
  localparam logic [15:0] RG_ILV_CH  = 16'h000D;
  localparam logic [15:0] RG_CLK_SRC = 16'h0010;
  localparam logic [15:0] RG_CLK_EXP = 16'h0011;

  localparam logic [1:0] CS_EXT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_REQ} seq_state_e;
endpackage

// File: rtl/cfg_seq_edge.sv
module cfg_seq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  p_no_double_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int LIMIT = 1024,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  p_cnt_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/cfg_seq_decode.sv
module cfg_seq_decode
  import cfg_seq_pkg::*;
#(
  parameter int ARG0_W = 16,
  parameter int ARG1_W = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEV_W  = 3
) (
  input  logic [7:0]        op_i,
  input  logic [ARG0_W-1:0] arg0_i,
  input  logic [ARG1_W-1:0] arg1_i,
  input  logic              step_i,
  input  logic [1:0]        clk_src_i,
  output logic [7:0]        reject_o,
  output logic              last_o,
  output logic              write_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic ch_bad;
  logic ch;
  assign ch_bad = arg1_i > ARG1_W'(1);
  assign ch     = arg1_i[0];

  always_comb begin
    reject_o = ST_OK;
    last_o   = 1'b1;
    write_o  = 1'b1;
    dev_o    = DEV_W'(DEV_ADC);
    addr_o   = '0;
    wdata_o  = '0;
    unique case (op_i)
      OP_CLK_SRC, OP_REINIT: begin
        if (op_i == OP_CLK_SRC && arg0_i > ARG0_W'(3)) reject_o = ST_BAD_ARG;
        dev_o   = DEV_W'(DEV_CLK);
        addr_o  = ADDR_W'(RG_CLK_SRC);
        wdata_o = (op_i == OP_REINIT) ? '0 : DATA_W'(arg0_i[1:0]);
      end
      OP_SELF_CAL: begin
        addr_o  = ADDR_W'(RG_CAL);
        wdata_o = DATA_W'(1);
      end
      OP_GAIN, OP_OFFSET: begin
        if (ch_bad) reject_o = ST_BAD_ARG;
        addr_o  = ADDR_W'((op_i == OP_GAIN) ? RG_GAIN : RG_OFFS) + ADDR_W'(ch);
        wdata_o = DATA_W'(arg0_i[8:0]);
      end
      OP_ILV: begin
        if (ch_bad) reject_o = ST_BAD_ARG;
        last_o  = step_i;
        addr_o  = ADDR_W'(step_i ? RG_ILV_CH : RG_ILV_EN);
        wdata_o = step_i ? DATA_W'(ch) : DATA_W'(arg0_i[0]);
      end
      OP_FDAC: begin
        dev_o   = DEV_W'(DEV_FDAC);
        wdata_o = DATA_W'(arg0_i);
      end
      OP_EE_RD, OP_EE_WR: begin
        write_o = (op_i == OP_EE_WR);
        dev_o   = DEV_W'(DEV_EE);
        addr_o  = ADDR_W'(arg0_i);
        wdata_o = (op_i == OP_EE_WR) ? DATA_W'(arg1_i) : '0;
      end
      OP_CLK_EXP: begin
        if (arg0_i != '0 && clk_src_i == CS_EXT) reject_o = ST_CONFLICT;
        dev_o   = DEV_W'(DEV_CLK);
        addr_o  = ADDR_W'(RG_CLK_EXP);
        wdata_o = DATA_W'(arg0_i != '0);
      end
      default: reject_o = ST_BAD_OP;
    endcase
  end
endmodule

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq
  import cfg_seq_pkg::*;
#(
  parameter int ARG0_W  = 16,
  parameter int ARG1_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int DEV_W   = 3,
  parameter int RET_W   = 8,
  parameter int TIMEOUT = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        cmd_op_i,
  input  logic [ARG0_W-1:0] cmd_arg0_i,
  input  logic [ARG1_W-1:0] cmd_arg1_i,
  input  logic              commit_i,
  output logic              idle_o,
  output logic [7:0]        status_o,
  output logic [RET_W-1:0]  ret_o,
  output logic [7:0]        err_o,
  output logic [1:0]        clk_src_o,
  output logic              clk_exp_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [DEV_W-1:0]  req_dev_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              req_ack_i,
  input  logic [RET_W-1:0]  req_rdata_i
);
  seq_state_e        state_q;
  logic [7:0]        op_q;
  logic [ARG0_W-1:0] arg0_q;
  logic [ARG1_W-1:0] arg1_q;
  logic              step_q;
  logic [7:0]        status_q;
  logic [RET_W-1:0]  ret_q;
  logic              err_q;
  logic [1:0]        clk_src_q;
  logic              clk_exp_q;

  logic       commit_rise, expire, last, done;
  logic [7:0] reject;

  cfg_seq_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (commit_i),
    .rise_o(commit_rise)
  );

  cfg_seq_decode #(
    .ARG0_W(ARG0_W), .ARG1_W(ARG1_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .DEV_W(DEV_W)
  ) u_dec (
    .op_i     (op_q),
    .arg0_i   (arg0_q),
    .arg1_i   (arg1_q),
    .step_i   (step_q),
    .clk_src_i(clk_src_q),
    .reject_o (reject),
    .last_o   (last),
    .write_o  (req_write_o),
    .dev_o    (req_dev_o),
    .addr_o   (req_addr_o),
    .wdata_o  (req_wdata_o)
  );

  cfg_seq_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (req_valid_o && !req_ack_i),
    .expire_o(expire)
  );

  assign req_valid_o = (state_q == S_REQ);
  assign done        = req_valid_o && req_ack_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      arg0_q    <= '0;
      arg1_q    <= '0;
      step_q    <= 1'b0;
      status_q  <= ST_OK;
      ret_q     <= '0;
      err_q     <= 1'b0;
      clk_src_q <= '0;
      clk_exp_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (commit_rise) begin
          op_q    <= cmd_op_i;
          arg0_q  <= cmd_arg0_i;
          arg1_q  <= cmd_arg1_i;
          step_q  <= 1'b0;
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (reject != ST_OK) begin
            status_q <= reject;
            state_q  <= S_IDLE;
          end else begin
            state_q <= S_REQ;
          end
        end
        S_REQ: begin
          if (req_ack_i && !last) begin
            step_q <= 1'b1;
          end else if (done) begin
            status_q <= ST_OK;
            state_q  <= S_IDLE;
            unique case (op_q)
              OP_CLK_SRC: begin
                clk_src_q <= arg0_q[1:0];
                if (arg0_q[1:0] == CS_EXT) clk_exp_q <= 1'b0;
              end
              OP_CLK_EXP: clk_exp_q <= (arg0_q != '0);
              OP_EE_RD:   ret_q <= req_rdata_i;
              OP_REINIT: begin
                err_q     <= 1'b0;
                clk_src_q <= '0;
                clk_exp_q <= 1'b0;
              end
              default: ;
            endcase
          end else if (expire) begin
            status_q <= ST_TIMEOUT;
            err_q    <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o    = (state_q == S_IDLE);
  assign status_o  = status_q;
  assign ret_o     = ret_q;
  assign err_o     = {7'd0, err_q};
  assign clk_src_o = clk_src_q;
  assign clk_exp_o = clk_exp_q;

  p_start_on_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle_o) |-> $past(commit_rise));
  p_idle_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && commit_rise) |=> !idle_o);
  p_valid_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !idle_o);
  p_ext_no_export_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_src_o == CS_EXT |-> !clk_exp_o);
  p_conflict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && op_q == OP_CLK_EXP && arg0_q != '0 && clk_src_o == CS_EXT)
      |=> idle_o && !req_valid_o && status_o == ST_CONFLICT && $stable(clk_exp_o));
  p_undef_op_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && reject == ST_BAD_OP) |=> idle_o && status_o == ST_BAD_OP);
  p_timeout_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ack_i && expire) |=> err_o != 8'd0 && status_o == ST_TIMEOUT);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 8'd0 && !(done && op_q == OP_REINIT)) |=> err_o != 8'd0);
  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ack_i && !expire)
      |=> req_valid_o && $stable(req_addr_o) && $stable(req_wdata_o) && $stable(req_dev_o));
endmodule

// File: tb/tb_cfg_cmd_seq.sv
module tb_cfg_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op = '0;
  logic [15:0] a0 = '0;
  logic [7:0]  a1 = '0;
  logic        commit = 1'b0;
  logic        idle, clk_exp, req_valid, req_write, ack = 1'b0;
  logic [7:0]  status, ret, err, rdata;
  logic [1:0]  clk_src;
  logic [2:0]  req_dev;
  logic [15:0] req_addr, req_wdata;

  int total = 0, bad = 0;
  bit resp_en = 1'b1;
  int dly = 0;
  int nreq = 0;
  logic [2:0]  log_dev [2];
  logic [15:0] log_addr[2];
  logic [15:0] log_wd  [2];
  logic        log_wr  [2];

  always #2.5 clk = ~clk;

  cfg_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_op_i(op), .cmd_arg0_i(a0), .cmd_arg1_i(a1),
    .commit_i(commit), .idle_o(idle), .status_o(status), .ret_o(ret), .err_o(err),
    .clk_src_o(clk_src), .clk_exp_o(clk_exp), .req_valid_o(req_valid),
    .req_write_o(req_write), .req_dev_o(req_dev), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .req_ack_i(ack), .req_rdata_i(rdata));

  assign rdata = req_addr[7:0] ^ 8'hA5;

  // responder: ack two cycles into each request, log its fields
  always @(negedge clk) begin
    if (ack) ack <= 1'b0;
    else if (req_valid && resp_en) begin
      if (dly == 2) begin
        if (nreq < 2) begin
          log_dev[nreq]  <= req_dev;
          log_addr[nreq] <= req_addr;
          log_wd[nreq]   <= req_wdata;
          log_wr[nreq]   <= req_write;
        end
        nreq <= nreq + 1;
        ack  <= 1'b1;
        dly  <= 0;
      end else dly <= dly + 1;
    end else dly <= 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] o, input logic [15:0] x0, input logic [7:0] x1,
                       input int hold);
    @(negedge clk);
    op = o; a0 = x0; a1 = x1; commit = 1'b1;
    nreq = 0;
    @(negedge clk);
    chk("R2 idle low after edge", idle, 0);
    for (int i = 1; i < hold; i++) @(negedge clk);
    commit = 1'b0;
    for (int i = 0; i < 3000 && !idle; i++) @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] a0;
    logic [7:0]  a1;
    logic [1:0]  n;
    logic [2:0]  dev;
    logic [15:0] ad0;
    logic [15:0] wd0;
    logic        wr0;
    logic [15:0] ad1;
    logic [15:0] wd1;
    logic [7:0]  st;
    logic [1:0]  cs;
    logic        ce;
    logic [7:0]  rt;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 16'h0001, 8'h00, 2'd1, 3'd1, 16'h0010, 16'h0001, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b0, 8'h00},
    '{8'h08, 16'h0001, 8'h00, 2'd1, 3'd1, 16'h0011, 16'h0001, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h02, 16'h01FF, 8'h01, 2'd1, 3'd0, 16'h0005, 16'h01FF, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h03, 16'h0100, 8'h00, 2'd1, 3'd0, 16'h0008, 16'h0100, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h04, 16'h0001, 8'h01, 2'd2, 3'd0, 16'h000C, 16'h0001, 1'b1, 16'h000D, 16'h0001, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h01, 16'h0000, 8'h00, 2'd1, 3'd0, 16'h0001, 16'h0001, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h05, 16'hBEEF, 8'h00, 2'd1, 3'd3, 16'h0000, 16'hBEEF, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h07, 16'h0123, 8'h5A, 2'd1, 3'd5, 16'h0123, 16'h005A, 1'b1, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'h00},
    '{8'h06, 16'h0042, 8'h00, 2'd1, 3'd5, 16'h0042, 16'h0000, 1'b0, 16'h0, 16'h0, 8'd0, 2'd1, 1'b1, 8'hE7},
    '{8'h09, 16'h0000, 8'h00, 2'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 16'h0, 16'h0, 8'd1, 2'd1, 1'b1, 8'hE7},
    '{8'h02, 16'h0010, 8'h02, 2'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 16'h0, 16'h0, 8'd2, 2'd1, 1'b1, 8'hE7},
    '{8'h00, 16'h0002, 8'h00, 2'd1, 3'd1, 16'h0010, 16'h0002, 1'b1, 16'h0, 16'h0, 8'd0, 2'd2, 1'b0, 8'hE7},
    '{8'h08, 16'h0001, 8'h00, 2'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 16'h0, 16'h0, 8'd3, 2'd2, 1'b0, 8'hE7},
    '{8'h00, 16'h0007, 8'h00, 2'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 16'h0, 16'h0, 8'd2, 2'd2, 1'b0, 8'hE7},
    '{8'h08, 16'h0000, 8'h00, 2'd1, 3'd1, 16'h0011, 16'h0000, 1'b1, 16'h0, 16'h0, 8'd0, 2'd2, 1'b0, 8'hE7}
  };

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 idle", idle, 1);
    chk("R12 status", status, 0);
    chk("R12 ret", ret, 0);
    chk("R12 err", err, 0);
    chk("R12 valid", req_valid, 0);
    chk("R12 clk_src/exp", {clk_src, clk_exp}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table: R3 R4 R5 R6 R7 R8 R9 R13
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].a0, VEC[v].a1, 1);
      chk($sformatf("R9 status v%0d", v), status, VEC[v].st);
      chk($sformatf("R9 nreq v%0d", v), nreq, VEC[v].n);
      if (VEC[v].n != 0) begin
        chk($sformatf("R5 dev v%0d", v), log_dev[0], VEC[v].dev);
        chk($sformatf("R5 addr v%0d", v), log_addr[0], VEC[v].ad0);
        chk($sformatf("R7 wdata v%0d", v), log_wd[0], VEC[v].wd0);
        chk($sformatf("R8 write v%0d", v), log_wr[0], VEC[v].wr0);
      end
      if (VEC[v].n == 2) begin
        chk($sformatf("R6 addr2 v%0d", v), log_addr[1], VEC[v].ad1);
        chk($sformatf("R6 wdata2 v%0d", v), log_wd[1], VEC[v].wd1);
      end
      chk($sformatf("R3 clk_src v%0d", v), clk_src, VEC[v].cs);
      chk($sformatf("R4 clk_exp v%0d", v), clk_exp, VEC[v].ce);
      chk($sformatf("R8 ret v%0d", v), ret, VEC[v].rt);
    end

    // R2: rejected command is idle-low for exactly one cycle
    @(negedge clk);
    op = 8'h20; commit = 1'b1; nreq = 0;
    @(negedge clk); commit = 1'b0;
    chk("R2 reject idle low", idle, 0);
    @(negedge clk);
    chk("R2 reject idle back", idle, 1);
    chk("R9 undefined status", status, 1);

    // R1: commit held high runs once
    issue(8'h01, 16'h0, 8'h0, 20);
    chk("R1 held commit single run", nreq, 1);
    repeat (5) @(negedge clk);
    chk("R1 no rerun while held", idle, 1);

    // R1: edge while busy ignored
    @(negedge clk);
    op = 8'h05; a0 = 16'h1111; commit = 1'b1; nreq = 0;
    @(negedge clk); commit = 1'b0;
    @(negedge clk); commit = 1'b1; a0 = 16'h2222;
    @(negedge clk); commit = 1'b0;
    for (int i = 0; i < 50 && !idle; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R1 busy edge ignored nreq", nreq, 1);
    chk("R1 busy edge data", log_wd[0], 16'h1111);
    chk("R1 idle after", idle, 1);

    // R10 timeout and sticky error
    resp_en = 1'b0;
    issue(8'h05, 16'h0033, 8'h0, 1);
    chk("R10 timeout status", status, 4);
    chk("R10 err set", err, 1);
    resp_en = 1'b1;
    issue(8'h01, 16'h0, 8'h0, 1);
    chk("R10 err sticky", err, 1);
    chk("R10 later cmd ok", status, 0);

    // R11 reinitialize
    issue(8'hFF, 16'h0, 8'h0, 1);
    chk("R11 err cleared", err, 0);
    chk("R11 clk_src", clk_src, 0);
    chk("R11 clk_exp", clk_exp, 0);
    chk("R11 status", status, 0);
    chk("R11 req addr", log_addr[0], 16'h0010);
    chk("R11 req data", log_wd[0], 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule